// File: doc/BRIEF.md
# Supply Rail Startup and Restart Sequencer

This block decides, cycle by cycle, when a switching controller may charge its own supply rail from the high-voltage input and when its power switch may run. It watches three rail comparator flags and a small vector of fault flags. All of these arrive already synchronized and debounced. It drives an enable for the charging current source and a permission for the power switch.

After reset the rail is charged with the switch held off. At the turn-on level charging stops and switching starts, unless a fault is present. While a fault blocks switching, the rail cycles between the minimum and turn-on levels under the source's control. If the rail sags below the minimum level while switching, a restart phase lets the switch keep running down to the lower reset level before the rail is recharged. Each time switching becomes permitted after being off, a one-cycle pulse is issued to launch soft-start.

The states are STARTUP, RUN, SELF_HOLD, SELF_CHARGE, RESTART, RECHARGE and FLAG_ERR. The transitions are listed below.

- **STARTUP / RECHARGE:** at turn-on, go to RUN, or to SELF_HOLD if a fault is present.
- **RUN:** a fault sends the block to SELF_CHARGE if the rail is below the minimum level, otherwise to SELF_HOLD. Without a fault, a rail below the minimum level sends it to RESTART.
- **SELF_HOLD:** a rail below the minimum level sends it to SELF_CHARGE. A cleared fault sends it to RUN.
- **SELF_CHARGE:** at turn-on, go to RUN, or to SELF_HOLD if the fault persists. A cleared fault with the rail above the minimum level sends it to RUN.
- **RESTART:** a fault leaves it the same way RUN does. Reaching the reset level sends it to RECHARGE. Recovering above the minimum level sends it back to RUN.
- **Any state:** an illegal flag combination sends it to FLAG_ERR.
- **FLAG_ERR:** returns to STARTUP once the flags are legal.

Top module: `rail_startup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters STARTUP. After that edge `src_en_o`=1, `sw_en_o`=0 and `start_pulse_o`=0.
- R2: In STARTUP the source stays on and the switch off until `rail_at_on_i`=1. At that edge, with no fault, the block moves to RUN: `src_en_o`=0 and `sw_en_o`=1. All outputs change one clock edge after the inputs that cause them.
- R3: If the turn-on level is reached while any fault bit is set, both `src_en_o` and `sw_en_o` are 0 after that edge.
- R4: While a fault holds the switch off, the source turns on when `rail_below_min_i`=1. It turns off again when `rail_at_on_i`=1, with `sw_en_o` remaining 0 throughout.
- R5: Any set fault bit forces `sw_en_o`=0 after the next clock edge, from every state.
- R6: When all faults clear while `rail_below_min_i`=0, switching resumes at the next edge. The source is not turned on.
- R7: If `rail_below_min_i`=1 during switching with no fault, the block enters RESTART: `sw_en_o` stays 1 and `src_en_o` stays 0.
- R8: In RESTART, `rail_below_rst_i`=1 gives `sw_en_o`=0 and `src_en_o`=1 after the edge. Switching is re-enabled only once `rail_at_on_i`=1.
- R9: `start_pulse_o` is high for exactly one cycle, namely the first cycle of RUN entered while `sw_en_o` was 0. It is not raised on a return from RESTART to RUN.
- R10: Two flag combinations are illegal: `rail_below_rst_i`=1 with `rail_below_min_i`=0, and `rail_below_min_i`=1 with `rail_at_on_i`=1. Either one forces `sw_en_o`=0 and `src_en_o`=0 after the edge. Once the flags are legal again, the block charges from STARTUP.
- R11: `sw_en_o` and `src_en_o` are never 1 in the same cycle.
- R12: `fault_i` bit 0 is line undervoltage, bit 1 is line overvoltage and bit 2 is thermal. Each bit alone stops switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_at_on_i | input | 1 | Rail at or above the turn-on level |
| rail_below_min_i | input | 1 | Rail below the minimum operating level |
| rail_below_rst_i | input | 1 | Rail below the reset level |
| fault_i | input | NUM_FAULTS | Fault flags (0 line UV, 1 line OV, 2 thermal) |
| sw_en_o | output | 1 | Power switch permitted to operate |
| src_en_o | output | 1 | High-voltage charging source enable |
| start_pulse_o | output | 1 | One-cycle soft-start launch pulse |

## Verification
The properties in the RTL check four things on every cycle: the source and switch enables are mutually exclusive, any fault or illegal flag set removes switch permission one edge later, and the start pulse never lasts two cycles. The ordering behaviours can only be shown by the bench's scenarios comparing against its own reference sequence. These are the two-level self-supply cycling, restart running down to the reset level, direct resumption after a fault clears above the minimum level, and the absence of a pulse on the return from RESTART to RUN.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_STARTUP     = 3'd0,
        ST_RUN         = 3'd1,
        ST_SELF_HOLD   = 3'd2,
        ST_SELF_CHARGE = 3'd3,
        ST_RESTART     = 3'd4,
        ST_RECHARGE    = 3'd5,
        ST_FLAG_ERR    = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic at_on;
        logic below_min;
        logic below_rst;
    } rail_flags_t;

endpackage

// File: rtl/rail_flag_qual.sv
module rail_flag_qual #(
    parameter int NUM_FAULTS = 3
) (
    input  rail_seq_pkg::rail_flags_t flags,
    input  logic [NUM_FAULTS-1:0]     fault_vec,
    output logic                      flags_bad,
    output logic                      fault_any
);
    logic rst_without_min;
    logic min_with_on;

    always_comb begin
        rst_without_min = flags.below_rst && !flags.below_min;
        min_with_on     = flags.below_min && flags.at_on;
        flags_bad       = rst_without_min || min_with_on;
        fault_any       = |fault_vec;
    end
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
    import rail_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  rail_flags_t flags,
    input  logic        flags_bad,
    input  logic        fault_any,
    output seq_state_t  state_q
);
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (flags_bad) begin
            state_d = ST_FLAG_ERR;
        end else begin
            unique case (state_q)
                ST_STARTUP, ST_RECHARGE: begin
                    if (flags.at_on)
                        state_d = fault_any ? ST_SELF_HOLD : ST_RUN;
                end
                ST_RUN, ST_RESTART: begin
                    if (fault_any)
                        state_d = flags.below_min ? ST_SELF_CHARGE : ST_SELF_HOLD;
                    else if (state_q == ST_RUN) begin
                        if (flags.below_min)
                            state_d = ST_RESTART;
                    end else if (flags.below_rst)
                        state_d = ST_RECHARGE;
                    else if (!flags.below_min)
                        state_d = ST_RUN;
                end
                ST_SELF_HOLD: begin
                    if (flags.below_min)
                        state_d = ST_SELF_CHARGE;
                    else if (!fault_any)
                        state_d = ST_RUN;
                end
                ST_SELF_CHARGE: begin
                    if (flags.at_on)
                        state_d = fault_any ? ST_SELF_HOLD : ST_RUN;
                    else if (!fault_any && !flags.below_min)
                        state_d = ST_RUN;
                end
                ST_FLAG_ERR: state_d = ST_STARTUP;
                default:     state_d = ST_FLAG_ERR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_STARTUP;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/rail_seq_out.sv
module rail_seq_out
    import rail_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state_q,
    output logic       sw_en,
    output logic       src_en,
    output logic       start_pulse
);
    logic was_sw_q;

    always_comb begin
        sw_en  = 1'b0;
        src_en = 1'b0;
        unique case (state_q)
            ST_STARTUP, ST_SELF_CHARGE, ST_RECHARGE: src_en = 1'b1;
            ST_RUN, ST_RESTART:                      sw_en  = 1'b1;
            default: ;
        endcase
        start_pulse = (state_q == ST_RUN) && !was_sw_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            was_sw_q <= 1'b0;
        else
            was_sw_q <= sw_en;
    end
endmodule

// File: rtl/rail_startup_seq.sv
module rail_startup_seq #(
    parameter int NUM_FAULTS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rail_at_on_i,
    input  logic                  rail_below_min_i,
    input  logic                  rail_below_rst_i,
    input  logic [NUM_FAULTS-1:0] fault_i,
    output logic                  sw_en_o,
    output logic                  src_en_o,
    output logic                  start_pulse_o
);
    import rail_seq_pkg::*;

    rail_flags_t flags;
    logic        flags_bad;
    logic        fault_any;
    seq_state_t  state_q;

    assign flags = '{at_on: rail_at_on_i, below_min: rail_below_min_i,
                     below_rst: rail_below_rst_i};

    rail_flag_qual #(.NUM_FAULTS(NUM_FAULTS)) u_qual (
        .flags     (flags),
        .fault_vec (fault_i),
        .flags_bad (flags_bad),
        .fault_any (fault_any)
    );

    rail_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flags),
        .flags_bad (flags_bad),
        .fault_any (fault_any),
        .state_q   (state_q)
    );

    rail_seq_out u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_q     (state_q),
        .sw_en       (sw_en_o),
        .src_en      (src_en_o),
        .start_pulse (start_pulse_o)
    );

    // R11
    no_both_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en_o && src_en_o));

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |=> !start_pulse_o);

    // R5
    fault_stops_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any |=> !sw_en_o);

    // R10
    bad_flags_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_bad |=> (!sw_en_o && !src_en_o));
endmodule

// File: tb/rail_startup_seq_test.sv
module rail_startup_seq_test;
    localparam int NF = 3;
    localparam int M_START = 0, M_RUN = 1, M_HOLD = 2, M_CHG = 3,
                   M_RST = 4, M_RECH = 5, M_ERR = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic at_on = 1'b0, below_min = 1'b1, below_rst = 1'b1;
    logic [NF-1:0] fault = '0;
    logic sw_en, src_en, start_pulse;

    int checks = 0, fails = 0;
    int m = M_START;
    bit prev_sw = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rail_startup_seq #(.NUM_FAULTS(NF)) uut (
        .clk(clk), .rst_n(rst_n), .rail_at_on_i(at_on),
        .rail_below_min_i(below_min), .rail_below_rst_i(below_rst),
        .fault_i(fault), .sw_en_o(sw_en), .src_en_o(src_en),
        .start_pulse_o(start_pulse));

    function automatic bit m_sw(int s);
        return (s == M_RUN) || (s == M_RST);
    endfunction

    function automatic bit m_src(int s);
        return (s == M_START) || (s == M_CHG) || (s == M_RECH);
    endfunction

    function automatic int m_next(int s, bit on, bit bmin, bit brst, bit flt);
        if ((brst && !bmin) || (bmin && on)) return M_ERR;
        case (s)
            M_START, M_RECH: return on ? (flt ? M_HOLD : M_RUN) : s;
            M_RUN: begin
                if (flt) return bmin ? M_CHG : M_HOLD;
                return bmin ? M_RST : M_RUN;
            end
            M_RST: begin
                if (flt) return bmin ? M_CHG : M_HOLD;
                if (brst) return M_RECH;
                return bmin ? M_RST : M_RUN;
            end
            M_HOLD: begin
                if (bmin) return M_CHG;
                return flt ? M_HOLD : M_RUN;
            end
            M_CHG: begin
                if (on) return flt ? M_HOLD : M_RUN;
                return (!flt && !bmin) ? M_RUN : M_CHG;
            end
            default: return M_START;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            M_START: return "R2";
            M_RUN:   return "R5";
            M_HOLD:  return "R6";
            M_CHG:   return "R4";
            M_RST:   return "R8";
            M_RECH:  return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic set_lvl(int lvl);
        at_on     = (lvl == 3);
        below_min = (lvl <= 1);
        below_rst = (lvl == 0);
    endtask

    // one clock edge; model follows; outputs sampled at the next falling edge
    task automatic step();
        int nx;
        nx = m_next(m, at_on, below_min, below_rst, |fault);
        @(posedge clk);
        @(negedge clk);
        prev_sw = m_sw(m);
        m = nx;
    endtask

    task automatic expect3(string tag, logic e_sw, logic e_src, logic e_p);
        chk(tag, "sw_en", sw_en, e_sw);
        chk(tag, "src_en", src_en, e_src);
        chk(tag, "start_pulse", start_pulse, e_p);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m = M_START;
        prev_sw = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        int r;
        int lvl;
        r = $urandom(32'd20240611);
        fault = '0;
        set_lvl(0);
        @(negedge clk);
        do_reset();
        expect3("R1", 1'b0, 1'b1, 1'b0);

        // startup charging
        set_lvl(1); step(); expect3("R2", 1'b0, 1'b1, 1'b0);
        set_lvl(2); step(); expect3("R2", 1'b0, 1'b1, 1'b0);
        set_lvl(3); step(); expect3("R2", 1'b1, 1'b0, 1'b1);
        step();             expect3("R9", 1'b1, 1'b0, 1'b0);
        set_lvl(2); step(); expect3("R2", 1'b1, 1'b0, 1'b0);

        // restart
        set_lvl(1); step(); expect3("R7", 1'b1, 1'b0, 1'b0);
        set_lvl(2); step(); expect3("R9", 1'b1, 1'b0, 1'b0);
        set_lvl(1); step(); expect3("R7", 1'b1, 1'b0, 1'b0);
        set_lvl(0); step(); expect3("R8", 1'b0, 1'b1, 1'b0);
        set_lvl(1); step(); expect3("R8", 1'b0, 1'b1, 1'b0);
        set_lvl(2); step(); expect3("R8", 1'b0, 1'b1, 1'b0);
        set_lvl(3); step(); expect3("R8", 1'b1, 1'b0, 1'b1);

        // thermal fault and self-supply cycling
        fault = 3'b100; step(); expect3("R12", 1'b0, 1'b0, 1'b0);
        set_lvl(2); step(); expect3("R4", 1'b0, 1'b0, 1'b0);
        set_lvl(1); step(); expect3("R4", 1'b0, 1'b1, 1'b0);
        set_lvl(2); step(); expect3("R4", 1'b0, 1'b1, 1'b0);
        set_lvl(3); step(); expect3("R4", 1'b0, 1'b0, 1'b0);
        set_lvl(2); step(); expect3("R4", 1'b0, 1'b0, 1'b0);
        fault = '0; step(); expect3("R6", 1'b1, 1'b0, 1'b1);

        // line undervoltage and overvoltage faults
        fault = 3'b001; step(); expect3("R12", 1'b0, 1'b0, 1'b0);
        fault = '0;     step(); expect3("R6", 1'b1, 1'b0, 1'b1);
        fault = 3'b010; step(); expect3("R5", 1'b0, 1'b0, 1'b0);
        fault = '0;     step(); expect3("R6", 1'b1, 1'b0, 1'b1);

        // fault present when turn-on level is reached
        set_lvl(0); do_reset(); expect3("R1", 1'b0, 1'b1, 1'b0);
        fault = 3'b010; set_lvl(3); step(); expect3("R3", 1'b0, 1'b0, 1'b0);
        fault = '0; step(); expect3("R6", 1'b1, 1'b0, 1'b1);

        // illegal flag combinations
        at_on = 1'b1; below_min = 1'b1; below_rst = 1'b0;
        step(); expect3("R10", 1'b0, 1'b0, 1'b0);
        set_lvl(2); step(); expect3("R10", 1'b0, 1'b1, 1'b0);
        set_lvl(3); step(); expect3("R10", 1'b1, 1'b0, 1'b1);
        at_on = 1'b0; below_min = 1'b0; below_rst = 1'b1;
        step(); expect3("R10", 1'b0, 1'b0, 1'b0);
        set_lvl(3); step(); expect3("R10", 1'b0, 1'b1, 1'b0);

        // constrained random walk against the reference sequence
        lvl = 3;
        for (int i = 0; i < 4000; i++) begin
            string tg;
            r = int'($urandom_range(99));
            if (r < 30 && lvl > 0) lvl--;
            else if (r < 60 && lvl < 3) lvl++;
            set_lvl(lvl);
            if ($urandom_range(99) < 6) fault = NF'($urandom_range(7));
            if ($urandom_range(99) < 2) begin
                at_on = 1'b1; below_min = 1'b1;
            end
            if ($urandom_range(999) < 3) begin
                do_reset();
                expect3("R1", 1'b0, 1'b1, 1'b0);
            end
            tg = tag_of(m);
            step();
            expect3(tg, m_sw(m), m_src(m), (m == M_RUN) && !prev_sw);
            chk("R11", "exclusive enables", sw_en && src_en, 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule